// File: doc/BRIEF.md
# Tap-Extending Accumulator and Output Hold Stage

This block sits behind the multiply-and-sum stages of a filter datapath. Each clock it receives one partial sum of products. It can fold that sum into a running total, so that several passes over a short tap array behave as one longer filter. A single active-low accumulate control ends a run. In the cycle the control is low, the finished total moves into a holding register, and the running total restarts from the sum that arrives in that same cycle. No idle cycle falls between two runs.

On its way into the holding register, the total can be rounded. A programmable bit position picks where rounding happens: half of that position's weight is added, and every bit below it is cleared. The incoming sum is widened to the accumulator width in one of two ways, chosen by a format input: zero extension for unsigned data, sign extension for two's complement data.

The held result leaves the block on a 28-bit bus split into a 9-bit low field and a 19-bit high field. Each field has its own active-low enable, and both enables are registered. A field that is switched off reads as zero rather than floating. A separate valid flag marks the cycle after each transfer into the holding register.

Top module: `accum_hold_out`

## Requirements
- R1: While the accumulate control `acc_en` is high, each clock adds the extended `sum_in` to the running total.
- R2: In a cycle where `acc_en` is low, the holding register takes the running total as it stood before that cycle's sum, and the running total is replaced by that cycle's extended `sum_in`. While `acc_en` stays high, the holding register does not change.
- R3: `dout_valid` is high for exactly the one cycle that follows each clock edge at which `acc_en` was low, and is low otherwise.
- R4: With `fmt_signed` = 1, `sum_in` is sign-extended from 24 to 28 bits. With `fmt_signed` = 0, it is zero-extended.
- R5: When `rnd_pos` = p with 1 <= p <= 27, the value loaded into the holding register is (total + 2^(p-1)) mod 2^28 with bits p-1..0 cleared. When p is 0 or p >= 28, the total is loaded unchanged.
- R6: `oe_lo_n` is registered on the rising clock edge. While the registered value is 1, `dout[8:0]` reads 0. While it is 0, those bits show the held result.
- R7: `oe_hi_n` is registered on the rising clock edge. While the registered value is 1, `dout[27:9]` reads 0. While it is 0, those bits show the held result.
- R8: While `rst_n` is low, the running total and the holding register clear, `dout_valid` is 0, and both registered enables are 1 (fields off), so `dout` reads 0.
- R9: The running total and the rounding add both wrap modulo 2^28, with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | 1: add to running total; 0: dump to hold register and restart |
| sum_in | input | 24 | Per-clock sum of products |
| fmt_signed | input | 1 | 1: two's complement data, 0: unsigned data |
| rnd_pos | input | 5 | Rounding bit position; 0 disables rounding |
| oe_lo_n | input | 1 | Active-low enable for bits 8..0 (registered) |
| oe_hi_n | input | 1 | Active-low enable for bits 27..9 (registered) |
| dout | output | 28 | Held result with disabled fields forced to zero |
| dout_valid | output | 1 | One-cycle flag after each hold-register load |

## Verification
The assertions watch several rules on every cycle. They check the one-cycle valid pulse after each dump and the stability of the holding register during accumulation. They check that a disabled field reads zero one edge after its enable was sampled high. They also check that the low bits of a rounded result are clear. The actual arithmetic can only be shown by the bench's scenarios, because it needs known input sequences to compare against. That covers the totals built across a run, the restart value after a back-to-back dump, the round-half-up results for positive and negative totals, the difference between zero and sign extension, and the wrap at 2^28.

// File: rtl/accum_pkg.sv
package accum_pkg;

    typedef enum logic {
        FMT_UNSIGNED = 1'b0,
        FMT_SIGNED   = 1'b1
    } data_fmt_e;

endpackage

// File: rtl/accum_core.sv
module accum_core #(
    parameter int SUM_W = 24,
    parameter int OUT_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic [SUM_W-1:0] sum_in,
    input  logic             fmt_signed,
    output logic [OUT_W-1:0] total_q
);
    import accum_pkg::*;

    localparam int EXT_W = OUT_W - SUM_W;

    typedef struct packed {
        logic [OUT_W-1:0] total;
    } core_st_t;

    core_st_t st_d, st_q;
    logic [OUT_W-1:0] sum_ext;
    logic             ext_bit;

    always_comb begin
        ext_bit  = (data_fmt_e'(fmt_signed) == FMT_SIGNED) ? sum_in[SUM_W-1] : 1'b0;
        sum_ext  = {{EXT_W{ext_bit}}, sum_in};
        st_d     = st_q;
        if (acc_en) begin
            st_d.total = st_q.total + sum_ext;
        end else begin
            // feedback path zeroed: restart with the current sum
            st_d.total = sum_ext;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign total_q = st_q.total;

endmodule

// File: rtl/accum_round.sv
module accum_round #(
    parameter int OUT_W = 28,
    parameter int POS_W = 5
) (
    input  logic [OUT_W-1:0] val_in,
    input  logic [POS_W-1:0] pos,
    output logic [OUT_W-1:0] val_out
);
    localparam logic [OUT_W-1:0] ONE = {{(OUT_W-1){1'b0}}, 1'b1};

    logic             active;
    logic [OUT_W-1:0] half;
    logic [OUT_W-1:0] keep_mask;
    logic [OUT_W-1:0] sum_half;

    always_comb begin
        active    = (pos != '0) && (32'(pos) < OUT_W);
        half      = '0;
        keep_mask = '1;
        if (active) begin
            half      = ONE << (pos - POS_W'(1));
            keep_mask = ~((ONE << pos) - ONE);
        end
        sum_half = val_in + half;
        val_out  = sum_half & keep_mask;
    end

endmodule

// File: rtl/accum_hold.sv
module accum_hold #(
    parameter int OUT_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dump,
    input  logic [OUT_W-1:0] rounded,
    output logic [OUT_W-1:0] hold_q,
    output logic             valid_q
);
    typedef struct packed {
        logic [OUT_W-1:0] hold;
        logic             valid;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = dump;
        if (dump) begin
            st_d.hold = rounded;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_q  = st_q.hold;
    assign valid_q = st_q.valid;

endmodule

// File: rtl/accum_out_gate.sv
module accum_out_gate #(
    parameter int OUT_W = 28,
    parameter int LO_W  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oe_lo_n,
    input  logic             oe_hi_n,
    input  logic [OUT_W-1:0] hold,
    output logic [OUT_W-1:0] dout
);
    localparam int HI_W = OUT_W - LO_W;

    typedef struct packed {
        logic lo_off;
        logic hi_off;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        st_d.lo_off = oe_lo_n;
        st_d.hi_off = oe_hi_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{lo_off: 1'b1, hi_off: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign dout[LO_W-1:0]     = st_q.lo_off ? '0 : hold[LO_W-1:0];
    assign dout[OUT_W-1:LO_W] = st_q.hi_off ? {HI_W{1'b0}} : hold[OUT_W-1:LO_W];

endmodule

// File: rtl/accum_hold_out.sv
module accum_hold_out #(
    parameter int SUM_W = 24,
    parameter int OUT_W = 28,
    parameter int LO_W  = 9,
    parameter int POS_W = $clog2(OUT_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic [SUM_W-1:0] sum_in,
    input  logic             fmt_signed,
    input  logic [POS_W-1:0] rnd_pos,
    input  logic             oe_lo_n,
    input  logic             oe_hi_n,
    output logic [OUT_W-1:0] dout,
    output logic             dout_valid
);
    logic [OUT_W-1:0] total_q;
    logic [OUT_W-1:0] rounded;
    logic [OUT_W-1:0] hold_q;

    accum_core #(.SUM_W(SUM_W), .OUT_W(OUT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_en     (acc_en),
        .sum_in     (sum_in),
        .fmt_signed (fmt_signed),
        .total_q    (total_q)
    );

    accum_round #(.OUT_W(OUT_W), .POS_W(POS_W)) u_round (
        .val_in  (total_q),
        .pos     (rnd_pos),
        .val_out (rounded)
    );

    accum_hold #(.OUT_W(OUT_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .dump    (!acc_en),
        .rounded (rounded),
        .hold_q  (hold_q),
        .valid_q (dout_valid)
    );

    accum_out_gate #(.OUT_W(OUT_W), .LO_W(LO_W)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .oe_lo_n (oe_lo_n),
        .oe_hi_n (oe_hi_n),
        .hold    (hold_q),
        .dout    (dout)
    );

endmodule

// File: rtl/accum_hold_chk.sv
module accum_hold_chk #(
    parameter int OUT_W = 28,
    parameter int LO_W  = 9,
    parameter int POS_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_en,
    input logic [POS_W-1:0] rnd_pos,
    input logic             oe_lo_n,
    input logic             oe_hi_n,
    input logic [OUT_W-1:0] dout,
    input logic             dout_valid,
    input logic [OUT_W-1:0] hold_q
);
    localparam logic [OUT_W-1:0] ONE = {{(OUT_W-1){1'b0}}, 1'b1};

    function automatic logic [OUT_W-1:0] low_mask(input logic [POS_W-1:0] p);
        if (p != '0 && 32'(p) < OUT_W) begin
            return (ONE << p) - ONE;
        end
        return '0;
    endfunction

    AST_VALID_AFTER_DUMP: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> dout_valid);                                   // R3
    AST_NO_VALID_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |=> !dout_valid);                                   // R3
    AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |=> $stable(hold_q));                               // R2
    AST_ROUND_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> ((hold_q & low_mask($past(rnd_pos))) == '0));  // R5
    AST_LO_FIELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        oe_lo_n |=> (dout[LO_W-1:0] == '0));                       // R6
    AST_HI_FIELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        oe_hi_n |=> (dout[OUT_W-1:LO_W] == '0));                   // R7

endmodule

bind accum_hold_out accum_hold_chk #(.OUT_W(OUT_W), .LO_W(LO_W), .POS_W(POS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_en     (acc_en),
    .rnd_pos    (rnd_pos),
    .oe_lo_n    (oe_lo_n),
    .oe_hi_n    (oe_hi_n),
    .dout       (dout),
    .dout_valid (dout_valid),
    .hold_q     (hold_q)
);

// File: tb/test_accum_hold_out.sv
`timescale 1ns/1ps
module test_accum_hold_out;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_en;
    logic [23:0] sum_in;
    logic        fmt_signed;
    logic [4:0]  rnd_pos;
    logic        oe_lo_n;
    logic        oe_hi_n;
    logic [27:0] dout;
    logic        dout_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    accum_hold_out i_accum_hold_out (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .sum_in(sum_in),
        .fmt_signed(fmt_signed), .rnd_pos(rnd_pos), .oe_lo_n(oe_lo_n),
        .oe_hi_n(oe_hi_n), .dout(dout), .dout_valid(dout_valid)
    );

    // {acc_en, sum_in, expected dout, expected valid}; signed, no rounding
    localparam int NV = 8;
    localparam logic [53:0] VEC [NV] = '{
        {1'b0, 24'd5,       28'd0,         1'b1},
        {1'b1, 24'd3,       28'd0,         1'b0},
        {1'b1, 24'hFFFFFE,  28'd0,         1'b0},
        {1'b0, 24'd10,      28'd6,         1'b1},
        {1'b1, 24'hFFFFEC,  28'd6,         1'b0},
        {1'b0, 24'd0,       28'hFFFFFF6,   1'b1},
        {1'b0, 24'd7,       28'd0,         1'b1},
        {1'b0, 24'd1,       28'd7,         1'b1}
    };

    task automatic chk(input string req, input logic [27:0] act, input logic [27:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic en, input logic [23:0] s);
        acc_en = en;
        sum_in = s;
        @(negedge clk);
    endtask

    initial begin
        #100000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; acc_en = 1'b1; sum_in = '0; fmt_signed = 1'b1;
        rnd_pos = '0; oe_lo_n = 1'b0; oe_hi_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 dout", dout, 28'd0);
        chk("R8 valid", {27'd0, dout_valid}, 28'd0);
        rst_n = 1'b1;
        step(1'b1, 24'd0);

        // R1 R2 R3 table walk
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][53], VEC[i][52:29]);
            chk($sformatf("R1/R2 vec%0d dout", i), dout, VEC[i][28:1]);
            chk($sformatf("R3 vec%0d valid", i), {27'd0, dout_valid}, {27'd0, VEC[i][0]});
        end

        // R5 rounding at position 4; total restarts from 1 left by table
        rnd_pos = 5'd4;
        step(1'b0, 24'd23);
        chk("R5 round 1", dout, 28'd0);
        step(1'b0, 24'd39);
        chk("R5 round 23", dout, 28'd16);
        step(1'b0, 24'd24);
        chk("R5 round 39", dout, 28'd32);
        step(1'b0, 24'hFFFFF7);
        chk("R5 round 24", dout, 28'd32);
        step(1'b0, 24'd0);
        chk("R5 round -9", dout, 28'hFFFFFF0);
        rnd_pos = 5'd30;
        step(1'b1, 24'd13);
        step(1'b0, 24'd0);
        chk("R5 pos 30 passthrough", dout, 28'd13);
        rnd_pos = 5'd0;

        // R4 unsigned vs signed extension
        fmt_signed = 1'b0;
        step(1'b1, 24'hFFFFFF);
        step(1'b1, 24'hFFFFFF);
        step(1'b0, 24'd0);
        chk("R4 unsigned", dout, 28'h1FFFFFE);
        // R9 wrap: 17 unsigned adds of 2^24-1 on top of 0
        for (int k = 0; k < 17; k++) step(1'b1, 24'hFFFFFF);
        step(1'b0, 24'd0);
        chk("R9 wrap", dout, 28'h0FFFFEF);
        fmt_signed = 1'b1;
        step(1'b1, 24'hFFFFFF);
        step(1'b1, 24'hFFFFFF);
        step(1'b0, 24'd0);
        chk("R4 signed", dout, 28'hFFFFFFE);

        // R2 hold unchanged during run
        step(1'b1, 24'd100);
        chk("R2 hold kept", dout, 28'hFFFFFFE);

        // R6 R7 registered enables
        oe_lo_n = 1'b1;
        #1;
        chk("R6 not yet registered", dout, 28'hFFFFFFE);
        step(1'b1, 24'd0);
        chk("R6 low off", dout, 28'hFFFFE00);
        oe_lo_n = 1'b0; oe_hi_n = 1'b1;
        step(1'b1, 24'd0);
        chk("R7 high off", dout, 28'h00001FE);
        oe_lo_n = 1'b1;
        step(1'b0, 24'd0);
        chk("R6/R7 both off", dout, 28'd0);
        chk("R3 valid with fields off", {27'd0, dout_valid}, 28'd1);
        oe_lo_n = 1'b0; oe_hi_n = 1'b0;
        step(1'b1, 24'd0);
        chk("R2 dump of 100", dout, 28'd100);

        // R8 reset mid-run
        rst_n = 1'b0;
        step(1'b0, 24'd5);
        chk("R8 mid reset dout", dout, 28'd0);
        chk("R8 mid reset valid", {27'd0, dout_valid}, 28'd0);
        rst_n = 1'b1;
        step(1'b1, 24'd0);
        step(1'b0, 24'd0);
        chk("R8 total cleared", dout, 28'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule